// File: doc/BRIEF.md
# Token-Chained Serial Event Readout

This block unloads the events a front-end chip has stored and sends them over one serial data line that many chips share. The chips are wired as a chain: each chip's end-of-readout pulse drives the next chip's start input. A chip that sees its start input rise sends its whole frame, one bit per clock, and raises its transmit-enable output for exactly the span in which it owns the line. It then emits a single-cycle end pulse that passes the token on.

A frame opens with the chip's 8-bit identifier. For every stored event it then carries that event's 12-bit bunch-crossing stamp, followed by one 26-bit record per channel. Each record holds a time value, an amplitude value, a gain-range flag and a hit flag. A configuration bit lets a chip skip its turn, and so does an empty event store; either way the token moves on at once. The event data sit in a small behavioural memory that the acquisition side fills through a write port.

Top module: `chain_readout`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_on`, `tx_data` and `end_out` are all low.
- R2: A rising edge on `start_in`, with `bypass` low and `stored_events` non-zero, makes `tx_on` high from the next cycle for exactly 8 + N·(12 + 26·NUM_CH) consecutive cycles, where N is `stored_events`.
- R3: The frame carries, MSB first and one bit per cycle: the 8-bit `chip_id`; then, for events 0 to N-1 in order, the 12-bit stamp, then the channel records for channels 0 to NUM_CH-1 in order. Each record is {time[25:14], amplitude[13:2], gain[1], hit[0]}.
- R4: Memory word ev·(NUM_CH+1) holds event ev's stamp in bits [11:0]. Word ev·(NUM_CH+1)+1+ch holds the record of channel ch.
- R5: `tx_data` is low in every cycle in which `tx_on` is low.
- R6: `end_out` is high for exactly one cycle, the first cycle after the last frame bit. It is never high together with `tx_on`.
- R7: A rising edge on `start_in` with `bypass` high sends nothing and gives the `end_out` pulse in the next cycle.
- R8: A rising edge on `start_in` with `stored_events` equal to 0 sends nothing and gives the `end_out` pulse in the next cycle.
- R9: The chip samples `chip_id`, `stored_events` and `bypass` at the start edge. A new start edge, or a change to those inputs, during transmission has no effect on the frame. Holding `start_in` high after the end pulse does not start a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Token in; its rising edge starts this chip's turn |
| bypass | input | 1 | Skip this chip's turn |
| chip_id | input | 8 | Identifier sent at the head of the frame |
| stored_events | input | $clog2(MAX_EV+1) | Number of stored events to send |
| wr_en | input | 1 | Event memory write strobe |
| wr_addr | input | $clog2(MAX_EV·(NUM_CH+1)) | Event memory word address |
| wr_data | input | 26 | Event memory write word |
| tx_on | output | 1 | High while this chip drives the shared line |
| tx_data | output | 1 | Serial data bit |
| end_out | output | 1 | One-cycle token-out pulse |

## Verification
The assertions assume that `stored_events` never exceeds MAX_EV when a start edge arrives. They also assume that every write address falls inside the memory. The memory is not written while a frame is going out. The stimulus loads exactly the words for the events it announces, and only while the chip is idle. It uses event counts from 0 up to the full depth of 16. The mid-frame disturbance test changes only the start, bypass, identifier and count inputs and never touches the memory.

// File: rtl/chainro_pkg.sv
package chainro_pkg;

    localparam int ID_W    = 8;
    localparam int STAMP_W = 12;
    localparam int TDC_W   = 12;
    localparam int ADC_W   = 12;
    localparam int REC_W   = TDC_W + ADC_W + 2;
    localparam int LEN_W   = $clog2(REC_W + 1);

    typedef enum logic [1:0] {
        FLD_ID,
        FLD_STAMP,
        FLD_CHAN,
        FLD_NONE
    } fld_e;

    typedef enum logic {
        TK_IDLE,
        TK_XMIT
    } tk_state_e;

    typedef struct packed {
        logic [TDC_W-1:0] tdc;
        logic [ADC_W-1:0] adc;
        logic             gain;
        logic             hit;
    } chan_rec_t;

    function automatic logic [LEN_W-1:0] fld_len(input fld_e f);
        case (f)
            FLD_ID:    return LEN_W'(ID_W);
            FLD_STAMP: return LEN_W'(STAMP_W);
            default:   return LEN_W'(REC_W);
        endcase
    endfunction

    // Place a right-justified field so its MSB is the first bit shifted out.
    function automatic logic [REC_W-1:0] align_msb(input logic [REC_W-1:0] w, input fld_e f);
        return w << (REC_W - int'(fld_len(f)));
    endfunction

endpackage

// File: rtl/chainro_event_mem.sv
module chainro_event_mem
    import chainro_pkg::*;
#(
    parameter int DEPTH = 80,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REC_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [REC_W-1:0] rd_data
);

    logic [REC_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];

    // Input assumption: the writer stays inside the array (R4).
    assert_wr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < DEPTH));

    assert_rd_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        int'(rd_addr) < DEPTH);

endmodule

// File: rtl/chainro_token_ctrl.sv
module chainro_token_ctrl
    import chainro_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_in,
    input  logic bypass,
    input  logic empty,
    input  logic last_bit,
    output logic load,
    output logic busy,
    output logic end_pulse
);

    tk_state_e st;
    logic      start_q;
    logic      rise;

    assign rise = start_in & ~start_q;
    assign busy = (st == TK_XMIT);

    always_comb begin
        load = (st == TK_IDLE) && rise && !bypass && !empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= TK_IDLE;
            start_q   <= 1'b0;
            end_pulse <= 1'b0;
        end else begin
            start_q   <= start_in;
            end_pulse <= 1'b0;
            case (st)
                TK_IDLE: begin
                    if (rise) begin
                        if (bypass || empty) begin
                            end_pulse <= 1'b1;
                        end else begin
                            st <= TK_XMIT;
                        end
                    end
                end
                TK_XMIT: begin
                    if (last_bit) begin
                        st        <= TK_IDLE;
                        end_pulse <= 1'b1;
                    end
                end
                default: st <= TK_IDLE;
            endcase
        end
    end

    assert_skip_gives_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && rise && (bypass || empty)) |=> (end_pulse && !busy));

    assert_end_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        end_pulse |=> !end_pulse);

    assert_end_follows_frame_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> end_pulse);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_bit) |=> busy);

endmodule

// File: rtl/chainro_serializer.sv
module chainro_serializer
    import chainro_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int MAX_EV = 16,
    localparam int DEPTH = MAX_EV * (NUM_CH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EVC_W = $clog2(MAX_EV + 1),
    localparam int EV_W  = (MAX_EV > 1) ? $clog2(MAX_EV) : 1,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             busy,
    input  logic [ID_W-1:0]  chip_id,
    input  logic [EVC_W-1:0] stored_events,
    input  logic [REC_W-1:0] rd_data,
    output logic [AW-1:0]    rd_addr,
    output logic             tx_bit,
    output logic             last_bit
);

    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

    fld_e             fld;
    fld_e             nxt_fld;
    logic [EV_W-1:0]  ev_idx;
    logic [EV_W-1:0]  nxt_ev;
    logic [CH_W-1:0]  ch_idx;
    logic [CH_W-1:0]  nxt_ch;
    logic [EVC_W-1:0] n_ev;
    logic [LEN_W-1:0] bit_idx;
    logic [REC_W-1:0] shreg;
    logic             field_end;

    // Look one field ahead so the memory word is ready at the field boundary.
    always_comb begin
        nxt_fld = FLD_NONE;
        nxt_ev  = ev_idx;
        nxt_ch  = ch_idx;
        case (fld)
            FLD_ID: begin
                nxt_fld = FLD_STAMP;
                nxt_ev  = '0;
                nxt_ch  = '0;
            end
            FLD_STAMP: begin
                nxt_fld = FLD_CHAN;
                nxt_ch  = '0;
            end
            FLD_CHAN: begin
                if (ch_idx != CH_LAST) begin
                    nxt_fld = FLD_CHAN;
                    nxt_ch  = ch_idx + CH_W'(1);
                end else if ((EVC_W'(ev_idx) + EVC_W'(1)) != n_ev) begin
                    nxt_fld = FLD_STAMP;
                    nxt_ev  = ev_idx + EV_W'(1);
                    nxt_ch  = '0;
                end
            end
            default: nxt_fld = FLD_NONE;
        endcase
    end

    always_comb begin
        rd_addr = AW'(int'(nxt_ev) * (NUM_CH + 1)
                      + ((nxt_fld == FLD_CHAN) ? int'(nxt_ch) + 1 : 0));
    end

    assign field_end = (bit_idx == LEN_W'(fld_len(fld) - LEN_W'(1)));
    assign last_bit  = busy && field_end && (nxt_fld == FLD_NONE);
    assign tx_bit    = shreg[REC_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            fld     <= FLD_NONE;
            ev_idx  <= '0;
            ch_idx  <= '0;
            n_ev    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (load) begin
            fld     <= FLD_ID;
            ev_idx  <= '0;
            ch_idx  <= '0;
            n_ev    <= stored_events;
            bit_idx <= '0;
            shreg   <= align_msb(REC_W'(chip_id), FLD_ID);
        end else if (busy) begin
            if (field_end) begin
                fld     <= nxt_fld;
                ev_idx  <= nxt_ev;
                ch_idx  <= nxt_ch;
                bit_idx <= '0;
                shreg   <= align_msb(rd_data, nxt_fld);
            end else begin
                bit_idx <= bit_idx + LEN_W'(1);
                shreg   <= shreg << 1;
            end
        end
    end

    // Input assumption: never more events announced than the store holds (R3).
    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> (int'(stored_events) <= MAX_EV));

    assert_bit_in_field_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx < fld_len(fld)));

    assert_event_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (EVC_W'(ev_idx) < n_ev));

    assert_frame_opens_with_id_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (fld == FLD_ID && bit_idx == '0));

endmodule

// File: rtl/chain_readout.sv
module chain_readout
    import chainro_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int MAX_EV = 16,
    localparam int DEPTH = MAX_EV * (NUM_CH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EVC_W = $clog2(MAX_EV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             bypass,
    input  logic [ID_W-1:0]  chip_id,
    input  logic [EVC_W-1:0] stored_events,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REC_W-1:0] wr_data,
    output logic             tx_on,
    output logic             tx_data,
    output logic             end_out
);

    logic             load;
    logic             busy;
    logic             last_bit;
    logic             end_pulse;
    logic             tx_bit;
    logic [AW-1:0]    rd_addr;
    logic [REC_W-1:0] rd_data;
    logic             empty;

    assign empty = (stored_events == '0);

    chainro_event_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    chainro_token_ctrl u_tok (
        .clk       (clk),
        .rst       (rst),
        .start_in  (start_in),
        .bypass    (bypass),
        .empty     (empty),
        .last_bit  (last_bit),
        .load      (load),
        .busy      (busy),
        .end_pulse (end_pulse)
    );

    chainro_serializer #(.NUM_CH(NUM_CH), .MAX_EV(MAX_EV)) u_ser (
        .clk           (clk),
        .rst           (rst),
        .load          (load),
        .busy          (busy),
        .chip_id       (chip_id),
        .stored_events (stored_events),
        .rd_data       (rd_data),
        .rd_addr       (rd_addr),
        .tx_bit        (tx_bit),
        .last_bit      (last_bit)
    );

    assign tx_on   = busy;
    assign tx_data = busy & tx_bit;
    assign end_out = end_pulse;

    assert_token_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(tx_on && end_out));

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!tx_on && !end_out));

endmodule

// File: tb/chain_readout_bench.sv
module chain_readout_bench;

    localparam int NUM_CH = 4;
    localparam int MAX_EV = 16;
    localparam int DEPTH  = MAX_EV * (NUM_CH + 1);
    localparam int AW     = $clog2(DEPTH);
    localparam int EVC_W  = $clog2(MAX_EV + 1);
    localparam int NVEC   = 6;

    // {bypass[21], events[20:16], chip id[15:8], data seed[7:0]}
    localparam logic [21:0] VECS [NVEC] = '{
        {1'b0, 5'd1,  8'hA5, 8'd3},
        {1'b0, 5'd3,  8'h3C, 8'd7},
        {1'b0, 5'd16, 8'hFF, 8'd11},
        {1'b1, 5'd4,  8'h12, 8'd19},
        {1'b0, 5'd0,  8'h77, 8'd23},
        {1'b0, 5'd2,  8'h00, 8'd200}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_in = 1'b0;
    logic             bypass = 1'b0;
    logic [7:0]       chip_id = 8'h00;
    logic [EVC_W-1:0] stored_events = '0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [25:0]      wr_data = '0;
    logic             tx_on;
    logic             tx_data;
    logic             end_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    logic exp_bits [0:2047];

    always #2 clk = ~clk;

    chain_readout #(.NUM_CH(NUM_CH), .MAX_EV(MAX_EV)) u_chain_readout (
        .clk           (clk),
        .rst           (rst),
        .start_in      (start_in),
        .bypass        (bypass),
        .chip_id       (chip_id),
        .stored_events (stored_events),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .tx_on         (tx_on),
        .tx_data       (tx_data),
        .end_out       (end_out)
    );

    function automatic logic [11:0] stamp_of(input int seed, input int ev);
        return 12'(seed * 37 + ev * 113 + 5);
    endfunction

    function automatic logic [25:0] rec_of(input int seed, input int ev, input int ch);
        return {12'(seed * 101 + ev * 17 + ch * 29),
                12'((seed * 59) ^ (ev * 7 + ch * 211)),
                1'(ev + ch + seed),
                1'(ev ^ ch ^ seed)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_mem(input int n, input int seed);
        for (int ev = 0; ev < n; ev++) begin
            // R4: stamp at word ev*(NUM_CH+1), channel ch at +1+ch
            wr_en   = 1'b1;
            wr_addr = AW'(ev * (NUM_CH + 1));
            wr_data = {14'b0, stamp_of(seed, ev)};
            @(negedge clk);
            for (int ch = 0; ch < NUM_CH; ch++) begin
                wr_addr = AW'(ev * (NUM_CH + 1) + 1 + ch);
                wr_data = rec_of(seed, ev, ch);
                @(negedge clk);
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic build_exp(input logic [7:0] id, input int n, input int seed, output int len);
        logic [11:0] st;
        logic [25:0] rc;
        len = 0;
        for (int b = 7; b >= 0; b--) begin exp_bits[len] = id[b]; len++; end
        for (int ev = 0; ev < n; ev++) begin
            st = stamp_of(seed, ev);
            for (int b = 11; b >= 0; b--) begin exp_bits[len] = st[b]; len++; end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                rc = rec_of(seed, ev, ch);
                for (int b = 25; b >= 0; b--) begin exp_bits[len] = rc[b]; len++; end
            end
        end
    endtask

    task automatic run_frame(input logic [7:0] id, input int n, input bit byp,
                             input int seed, input bit disturb);
        int len;
        int cnt;
        int mis;
        int first_bad;
        load_mem(n, seed);
        build_exp(id, n, seed, len);
        if (byp || n == 0) len = 0;
        chip_id       = id;
        stored_events = EVC_W'(n);
        bypass        = byp;
        start_in      = 1'b1;
        @(negedge clk);
        cnt = 0;
        mis = 0;
        first_bad = -1;
        while (tx_on && cnt < 4000) begin
            if (cnt < 2048 && tx_data !== exp_bits[cnt]) begin
                mis++;
                if (first_bad < 0) first_bad = cnt;
            end
            if (disturb && cnt == 10) start_in = 1'b0;
            if (disturb && cnt == 11) begin
                // R9: late edge and changed inputs during the frame
                start_in      = 1'b1;
                chip_id       = ~id;
                stored_events = EVC_W'(1);
                bypass        = 1'b1;
            end
            cnt++;
            @(negedge clk);
        end
        check(cnt == len, byp ? "R7 no bits when bypassed" :
                          (n == 0) ? "R8 no bits when empty" : "R2 frame length", cnt, len);
        check(mis == 0, "R3 R4 frame content (first bad bit index as actual)", first_bad, -1);
        check(end_out === 1'b1, "R6 end pulse after last bit / R7 R8 skip pulse", int'(end_out), 1);
        check(tx_data === 1'b0, "R5 line low when not transmitting", int'(tx_data), 0);
        @(negedge clk);
        check(end_out === 1'b0, "R6 end pulse one cycle wide", int'(end_out), 0);
        check(tx_on === 1'b0, "R9 held start gives no second frame", int'(tx_on), 0);
        start_in = 1'b0;
        bypass   = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(tx_on === 1'b0 && end_out === 1'b0 && tx_data === 1'b0,
              "R1 outputs low in reset", int'({tx_on, tx_data, end_out}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_on === 1'b0 && end_out === 1'b0 && tx_data === 1'b0,
              "R1 outputs low after reset", int'({tx_on, tx_data, end_out}), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i][15:8], int'(VECS[i][20:16]), VECS[i][21],
                      int'(VECS[i][7:0]), 1'b0);
        end

        // R9: start edge and input changes during the frame are ignored
        run_frame(8'h5A, 2, 1'b0, 41, 1'b1);

        // R7: bypass with a full store still sends nothing
        run_frame(8'hC3, MAX_EV, 1'b1, 5, 1'b0);

        // R5: idle line stays low over several cycles
        for (int k = 0; k < 4; k++) begin
            check(tx_on === 1'b0 && tx_data === 1'b0, "R5 idle line low",
                  int'({tx_on, tx_data}), 0);
            @(negedge clk);
        end

        // R2 R3: a second chip identifier back to back after an idle frame
        run_frame(8'h81, 1, 1'b0, 99, 1'b0);

        finish_run();
    end

endmodule